// File: doc/BRIEF.md
# Retention Refresh Request Scheduler

A nonvolatile memory that sits in a very hot environment loses charge over time, so its contents must be rewritten now and then. This block tells a host when that rewrite is due. It raises a request flag as soon as power-on reset is released. If nobody answers that first request within a short window, the block drops it by itself and records the fact. Independently, the block keeps a long interval timer, 30 days at the default setting. When the timer runs out, it raises the request again and holds it until the host answers.

The host answers with a one-cycle acknowledge. The acknowledge withdraws the request, marks the block busy and restarts the interval. When the rewrite is finished, the host pulses a done strobe and the block returns to idle. A parameterised prescaler turns clock cycles into seconds. Both time constants are parameters too, so a simulation can shrink days to cycles. The memory array, the rewrite sequence and the host bus are not part of this block.

Top module: `nvm_refresh_sched`

## Requirements
- R1: While rst_n is low, and in every cycle after release until another rule applies, refresh_req is 1 and status is 3'b000.
- R2: One second lasts CLK_PER_SEC clock cycles. Seconds are aligned to reset release: the k-th second ends at the k*CLK_PER_SEC-th rising edge after release. Every timed event below takes effect one edge after the second boundary that completes it.
- R3: If the power-on request gets no acknowledge, refresh_req falls at edge POR_WINDOW_S*CLK_PER_SEC+1 after release. At the same edge status bit 0 (power-on request expired) becomes 1, and it stays 1 until the next reset. An acknowledged power-on request leaves bit 0 at 0.
- R4: A host_ack sampled while refresh_req is 1 clears refresh_req at that edge, sets status bit 1 (busy) and restarts the interval count from zero.
- R5: host_done sampled while busy clears status bit 1. host_done at any other time has no effect.
- R6: A periodic request rises at edge (floor(E/CLK_PER_SEC)+PERIOD_S)*CLK_PER_SEC+1. Here E is the edge of the last accepted acknowledge, or 0 if there has been none since release. Status bit 2 (periodic request pending) is 1 exactly while that request stands.
- R7: A periodic request never times out. It stays asserted, with status bit 2 set, until it is acknowledged.
- R8: host_ack sampled while refresh_req is 0 has no effect on the outputs and does not restart the interval.
- R9: If the interval runs out while the block is busy, the periodic request rises one edge after the host_done that ends the busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| host_ack | input | 1 | Host accepts the standing refresh request |
| host_done | input | 1 | Host reports that the rewrite has finished |
| refresh_req | output | 1 | Refresh request to the host |
| status | output | 3 | bit0 power-on request expired, bit1 busy, bit2 periodic request pending |

## Verification
A wrong internal state shows at the ports in one of two ways. A corrupt state register shows at once as a request and a status combination that cannot occur. A corrupt or misaligned seconds count shows only as a request edge in the wrong cycle, which may be up to a full interval later. For that reason every timed event is checked at the exact edge R2 and R6 predict and also one edge earlier. Acknowledges are placed at random points within a second, so a prescaler that is not aligned to reset release produces a misplaced periodic edge.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    localparam int STAT_W = 3;

    // status bit positions
    localparam int ST_BIT_POR_EXP = 0;
    localparam int ST_BIT_BUSY    = 1;
    localparam int ST_BIT_PERIOD  = 2;

    typedef enum logic [1:0] {
        ST_POR_REQ = 2'd0,
        ST_IDLE    = 2'd1,
        ST_BUSY    = 2'd2,
        ST_PER_REQ = 2'd3
    } rfs_state_e;

    typedef struct packed {
        rfs_state_e state;
        logic       por_exp;
    } rfs_ctl_t;

endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
    parameter int CLK_PER_SEC = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic sec_tick
);
    generate
        if (CLK_PER_SEC <= 1) begin : g_passthru
            assign sec_tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(CLK_PER_SEC);
            localparam logic [PW-1:0] LAST = PW'(CLK_PER_SEC - 1);

            logic [PW-1:0] pre_d, pre_q;

            always_comb begin
                if (pre_q == LAST) pre_d = '0;
                else               pre_d = pre_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end

            assign sec_tick = (pre_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/rfs_sec_cnt.sv
module rfs_sec_cnt #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic sec_tick,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (en && sec_tick && (cnt_q != LIM))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = (cnt_q == LIM);
endmodule

// File: rtl/nvm_refresh_sched.sv
module nvm_refresh_sched
    import rfs_pkg::*;
#(
    parameter int CLK_PER_SEC  = 50_000_000,
    parameter int POR_WINDOW_S = 20,
    parameter int PERIOD_S     = 2_592_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_ack,
    input  logic              host_done,
    output logic              refresh_req,
    output logic [STAT_W-1:0] status
);
    rfs_ctl_t ctl_d, ctl_q;
    logic     sec_tick;
    logic     por_hit;
    logic     ivl_hit;
    logic     restart;
    logic     in_por;

    assign in_por  = (ctl_q.state == ST_POR_REQ);
    assign restart = host_ack && (in_por || (ctl_q.state == ST_PER_REQ));

    rfs_tick_gen #(.CLK_PER_SEC(CLK_PER_SEC)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick)
    );

    rfs_sec_cnt #(.LIMIT(POR_WINDOW_S)) u_por_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (1'b0),
        .en       (in_por),
        .sec_tick (sec_tick),
        .hit      (por_hit)
    );

    rfs_sec_cnt #(.LIMIT(PERIOD_S)) u_ivl_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (restart),
        .en       (1'b1),
        .sec_tick (sec_tick),
        .hit      (ivl_hit)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_POR_REQ: begin
                if (host_ack) begin
                    ctl_d.state = ST_BUSY;
                end else if (por_hit) begin
                    ctl_d.state   = ST_IDLE;
                    ctl_d.por_exp = 1'b1;
                end
            end
            ST_IDLE: begin
                if (ivl_hit) ctl_d.state = ST_PER_REQ;
            end
            ST_BUSY: begin
                if (host_done) ctl_d.state = ST_IDLE;
            end
            ST_PER_REQ: begin
                if (host_ack) ctl_d.state = ST_BUSY;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state   <= ST_POR_REQ;
            ctl_q.por_exp <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign refresh_req = in_por || (ctl_q.state == ST_PER_REQ);

    always_comb begin
        status                 = '0;
        status[ST_BIT_POR_EXP] = ctl_q.por_exp;
        status[ST_BIT_BUSY]    = (ctl_q.state == ST_BUSY);
        status[ST_BIT_PERIOD]  = (ctl_q.state == ST_PER_REQ);
    end
endmodule

// File: rtl/nvm_refresh_sched_chk.sv
module nvm_refresh_sched_chk
    import rfs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_ack,
    input logic              host_done,
    input logic              refresh_req,
    input logic [STAT_W-1:0] status
);
    // R1: request stands across reset release
    p_req_at_release_r1: assert property (@(posedge clk)
        !rst_n |=> refresh_req);

    // R4: accepted acknowledge withdraws the request and marks busy
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req && host_ack |=> !refresh_req && status[ST_BIT_BUSY]);

    // R5: done ends the busy state
    p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_BIT_BUSY] && host_done |=> !status[ST_BIT_BUSY]);

    // R7: periodic request holds until acknowledged
    p_periodic_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_BIT_PERIOD] && !host_ack |=> refresh_req && status[ST_BIT_PERIOD]);

    // R3: expiry flag appears only as the power-on request is dropped
    p_por_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_BIT_POR_EXP]) |-> !refresh_req && $past(refresh_req)
                                          && !$past(status[ST_BIT_PERIOD]));

    // R8: busy and a standing request never coexist
    p_busy_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_BIT_BUSY] |-> !refresh_req);

    // R5: done outside busy does not create busy
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !status[ST_BIT_BUSY] && !refresh_req && host_done |=> !status[ST_BIT_BUSY]);
endmodule

bind nvm_refresh_sched nvm_refresh_sched_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ack    (host_ack),
    .host_done   (host_done),
    .refresh_req (refresh_req),
    .status      (status)
);

// File: tb/nvm_refresh_sched_bench.sv
`timescale 1ns/1ps
module nvm_refresh_sched_bench;
    localparam int N = 4;
    localparam int W = 5;
    localparam int P = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_ack = 1'b0;
    logic       host_done = 1'b0;
    logic       refresh_req;
    logic [2:0] status;

    int n_chk = 0;
    int n_fail = 0;
    int ecnt = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    nvm_refresh_sched #(.CLK_PER_SEC(N), .POR_WINDOW_S(W), .PERIOD_S(P)) u_nvm_refresh_sched (
        .clk(clk), .rst_n(rst_n), .host_ack(host_ack), .host_done(host_done),
        .refresh_req(refresh_req), .status(status)
    );

    // edge at which a periodic request appears after restart at edge e (R6)
    function automatic int due_edge(input int e);
        return ((e / N) + P) * N + 1;
    endfunction

    task automatic check(input logic req_e, input logic [2:0] st_e, input string tag);
        n_chk++;
        if (refresh_req !== req_e || status !== st_e) begin
            n_fail++;
            $display("FAIL %s edge %0d: req=%b status=%b expected req=%b status=%b",
                     tag, ecnt, refresh_req, status, req_e, st_e);
        end
    endtask

    task automatic wait_until(input int k);
        while (ecnt < k) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; host_ack = 1'b0; host_done = 1'b0;
        repeat (2) @(negedge clk);
        check(1'b1, 3'b000, "R1 in reset");
        rst_n = 1'b1;
    endtask

    // drive a one-cycle strobe sampled at edge k; returns at the negedge after edge k
    task automatic ack_at(input int k);
        wait_until(k - 1);
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
    endtask

    task automatic done_at(input int k);
        wait_until(k - 1);
        host_done = 1'b1;
        @(negedge clk);
        host_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));

        // ---- directed: unserviced power-on request
        do_reset();
        wait_until(1);          check(1'b1, 3'b000, "R1 after release");
        wait_until(W*N);        check(1'b1, 3'b000, "R2 window not yet over");
        wait_until(W*N + 1);    check(1'b0, 3'b001, "R3 timeout");
        ack_at(30);             check(1'b0, 3'b001, "R8 ack idle ignored");
        done_at(40);            check(1'b0, 3'b001, "R5 done idle ignored");
        wait_until(P*N);        check(1'b0, 3'b001, "R6 before period");
        wait_until(P*N + 1);    check(1'b1, 3'b101, "R6 periodic rise, R8 no restart");
        wait_until(200);        check(1'b1, 3'b101, "R7 holds");
        ack_at(210);            check(1'b0, 3'b011, "R4 ack periodic");
        done_at(215);           check(1'b0, 3'b001, "R5 done");
        wait_until(due_edge(210) - 1); check(1'b0, 3'b001, "R6 before second");
        wait_until(due_edge(210));     check(1'b1, 3'b101, "R6 second periodic");
        ack_at(330);            check(1'b0, 3'b011, "R4 ack again");
        ack_at(400);            check(1'b0, 3'b011, "R8 ack busy ignored");
        wait_until(470 - 1);    check(1'b0, 3'b011, "R9 still busy after due");
        done_at(470);           check(1'b0, 3'b001, "R9 done");
        @(negedge clk);         check(1'b1, 3'b101, "R9 deferred periodic");

        // ---- directed: serviced power-on request
        do_reset();
        ack_at(7);              check(1'b0, 3'b010, "R4 ack power-on");
        done_at(9);             check(1'b0, 3'b000, "R5 done power-on");
        wait_until(W*N + 3);    check(1'b0, 3'b000, "R3 no expiry after service");
        wait_until(due_edge(7) - 1); check(1'b0, 3'b000, "R6 before period");
        wait_until(due_edge(7));     check(1'b1, 3'b100, "R6 period from ack");

        // ---- random rounds
        for (int r = 0; r < 8; r++) begin
            int e;
            int d;
            logic [2:0] base;
            do_reset();
            if ($urandom % 2 == 1) begin
                e = 1 + ($urandom % (W*N));
                ack_at(e);      check(1'b0, 3'b010, "R4 rand power-on ack");
                d = e + 1 + ($urandom % 6);
                done_at(d);     check(1'b0, 3'b000, "R5 rand done");
                base = 3'b000;
            end else begin
                e = 0;
                wait_until(W*N + 1); check(1'b0, 3'b001, "R3 rand timeout");
                base = 3'b001;
            end
            for (int k = 0; k < 2; k++) begin
                wait_until(due_edge(e) - 1); check(1'b0, base, "R6 rand before");
                wait_until(due_edge(e));     check(1'b1, base | 3'b100, "R6 rand rise");
                e = due_edge(e) + ($urandom % 13);
                ack_at(e);      check(1'b0, base | 3'b010, "R4 rand ack");
                done_at(e + 1 + ($urandom % 5)); check(1'b0, base, "R5 rand done");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule